// File: doc/BRIEF.md
# Control Packet Address Queue and Host Row Reader

This block keeps a queue of shared-memory start addresses, one per arriving control packet. Each accepted arrival raises a level interrupt, and a counter shows how many addresses are waiting. Software uses a small register file to work through the queue. It copies the head address into a row address register, optionally edits that address, and starts a row fetch from shared memory. It then reads the fetched row one 32-bit word at a time through a pointer/data window. Once a packet has been handled, software frees the head entry.

A configuration pin marks the device as master or slave. The copy-head and free commands only act on a master device. A row fetch works on either. Two expansion pins select which additional row, if any, belongs to a packet. The block offers that row address as a read-only register.

Arrivals come in on a valid/ready stream whose ready output is always high. When the queue is full, an arrival is still taken from the stream but its address is dropped. The shared-memory request is a valid/ready port. Valid, address and priority stay stable until ready is seen. The response is a single-cycle valid pulse that cannot be back-pressured, and it comes only after a request has been granted.

Top module: `cpq_host_seq`

Register map (`hst_addr`):
- 0: command (write). Bits [2:0]: 1 = copy head, 2 = free head, 3 = row fetch. Other codes do nothing.
- 1: row address (read/write).
- 2: word pointer (read/write).
- 3: word data (read).
- 4: status (read). [7:0] = queued count, [8] = busy, [9] = overflow, [10] = command ignored. Bits 9 and 10 are cleared by writing 1.
- 5: interrupt. Bit 0 reads the interrupt and is cleared by writing 1.
- 6: second row. Bit 31 = second row exists, low bits = its address.

## Requirements
- R1: An arrival (`arr_valid`) is accepted when fewer than `Q_DEPTH` addresses are queued, or when the queue is full and a free takes effect in the same cycle. Queued addresses leave in arrival order.
- R2: Each accepted arrival sets `irq`, which is also read at register 5 bit 0. It stays set until software writes 1 to register 5 bit 0. An accepted arrival in the same cycle as that clear leaves it set.
- R3: Status bits [7:0] always equal the number of queued addresses, and the count never exceeds `Q_DEPTH`.
- R4: Command code 1 on a master copies the head address into the row address register (register 1) without removing it. On an empty queue the register is unchanged.
- R5: Command code 2 on a master removes the head entry. On an empty queue it has no effect.
- R6: Command code 3 raises a memory request at the row address. The request address stays stable until granted. The row captured from the response becomes readable, and status bit 8 stays set from the fetch command until the response cycle.
- R7: Reading register 3 returns 32-bit word number P of the fetched row, where P is the value in register 2. Word 0 is row bits [31:0].
- R8: With `cfg_master` low, codes 1 and 2 change neither the queue nor the row address. Code 3 still fetches.
- R9: Any command write while status bit 8 is set is ignored and sets status bit 10, which stays set until cleared by writing 1.
- R10: An arrival that is not accepted is dropped and sets status bit 9, which stays set until cleared by writing 1.
- R11: Register 6 gives the second row of the packet at the current row address A. With both expansion pins low it is {1, A+1}. With only internal expansion high it is {1, A+256}. With external expansion high it reads 0.
- R12: `mem_req_prio` equals `cfg_prio_en` as sampled at the fetch command, and it holds until the request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | Device is master |
| cfg_ext_exp | input | 1 | External expansion on |
| cfg_int_exp | input | 1 | Internal expansion on |
| cfg_prio_en | input | 1 | Priority for host memory accesses |
| arr_valid | input | 1 | Control packet arrival |
| arr_ready | output | 1 | Always high |
| arr_addr | input | ROW_AW | Start row of the arriving packet |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 3 | Host register index |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` |
| irq | output | 1 | Arrival interrupt |
| mem_req_valid | output | 1 | Row read request |
| mem_req_ready | input | 1 | Grant |
| mem_req_addr | output | ROW_AW | Row to read |
| mem_req_prio | output | 1 | Raised priority |
| mem_rsp_valid | input | 1 | Row data valid |
| mem_rsp_data | input | ROW_WORDS*32 | Row data |

## Verification
Arrivals and host commands reach the queue in the same cycle. The bench provokes this in two ways. It drives an arrival in the same cycle as a free while the queue is full, and it drives an arrival in the same cycle as an interrupt clear. A behavioural reference model holds a queue of addresses and checks the count, the flags and the interrupt on every clock. That model expects the full-queue arrival to be kept with the count unchanged, and it expects the interrupt to stay set. A command issued while a fetch is waiting for grant is judged the same way: the count and row address must be unchanged, and the ignore flag must be set.

// File: rtl/cpq_pkg.sv
package cpq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_COPY = 3'd1,
    CMD_FREE = 3'd2,
    CMD_RROW = 3'd3
  } cmd_e;

  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_ROW  = 3'd1;
  localparam logic [2:0] RA_PTR  = 3'd2;
  localparam logic [2:0] RA_DATA = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;
  localparam logic [2:0] RA_INT  = 3'd5;
  localparam logic [2:0] RA_NEXT = 3'd6;

  localparam int ST_BUSY = 8;
  localparam int ST_OVF  = 9;
  localparam int ST_IGN  = 10;

  typedef enum logic [1:0] {
    MP_IDLE = 2'd0,
    MP_REQ  = 2'd1,
    MP_WAIT = 2'd2
  } mp_state_e;
endpackage

// File: rtl/cpq_addr_fifo.sv
module cpq_addr_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 12,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          push_ok,
  output logic          drop
);
  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic          full, pop_eff;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_eff = pop && !empty;
  assign push_ok = push && (!full || pop_eff);
  assign drop    = push && !push_ok;
  assign head    = slot_q[rd_q];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (push_ok) begin
        slot_q[wr_q] <= push_data;
        wr_q         <= bump(wr_q);
      end
      if (pop_eff) rd_q <= bump(rd_q);
      case ({push_ok, pop_eff})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_DROP_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count))); // R10
  AST_SWAP_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && pop) |=> (count == $past(count))); // R1
endmodule

// File: rtl/cpq_mem_port.sv
module cpq_mem_port
  import cpq_pkg::*;
#(
  parameter int AW = 12,
  parameter int RW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          start_prio,
  output logic          busy,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_prio,
  input  logic          rsp_valid,
  input  logic [RW-1:0] rsp_data,
  output logic [RW-1:0] row
);
  mp_state_e     st_q;
  logic [AW-1:0] addr_q;
  logic          prio_q;
  logic [RW-1:0] row_q;

  assign busy      = (st_q != MP_IDLE);
  assign req_valid = (st_q == MP_REQ);
  assign req_addr  = addr_q;
  assign req_prio  = prio_q;
  assign row       = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= MP_IDLE;
      addr_q <= '0;
      prio_q <= 1'b0;
      row_q  <= '0;
    end else begin
      case (st_q)
        MP_IDLE: if (start) begin
          st_q   <= MP_REQ;
          addr_q <= start_addr;
          prio_q <= start_prio;
        end
        MP_REQ:  if (req_ready) st_q <= MP_WAIT;
        MP_WAIT: if (rsp_valid) begin
          st_q  <= MP_IDLE;
          row_q <= rsp_data;
        end
        default: st_q <= MP_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R6
  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(req_prio)); // R12
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R6
  AST_RSP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MP_WAIT && rsp_valid) |=> !busy); // R6
endmodule

// File: rtl/cpq_row_map.sv
module cpq_row_map #(
  parameter int AW     = 12,
  parameter int STRIDE = 256
) (
  input  logic          ext_exp,
  input  logic          int_exp,
  input  logic [AW-1:0] base,
  output logic          nxt_valid,
  output logic [AW-1:0] nxt_addr
);
  localparam logic [AW-1:0] STEP_INT = AW'(STRIDE);
  localparam logic [AW-1:0] STEP_ONE = AW'(1);

  always_comb begin
    nxt_valid = !ext_exp;
    nxt_addr  = '0;
    if (!ext_exp) nxt_addr = base + (int_exp ? STEP_INT : STEP_ONE);
  end
endmodule

// File: rtl/cpq_host_seq.sv
module cpq_host_seq
  import cpq_pkg::*;
#(
  parameter int ROW_AW     = 12,
  parameter int Q_DEPTH    = 8,
  parameter int ROW_WORDS  = 4,
  parameter int INT_STRIDE = 256,
  localparam int ROW_BITS  = ROW_WORDS * 32,
  localparam int PTR_W     = $clog2(ROW_WORDS),
  localparam int CNT_W     = $clog2(Q_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic                cfg_ext_exp,
  input  logic                cfg_int_exp,
  input  logic                cfg_prio_en,
  input  logic                arr_valid,
  output logic                arr_ready,
  input  logic [ROW_AW-1:0]   arr_addr,
  input  logic                hst_we,
  input  logic [2:0]          hst_addr,
  input  logic [31:0]         hst_wdata,
  output logic [31:0]         hst_rdata,
  output logic                irq,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ROW_AW-1:0]   mem_req_addr,
  output logic                mem_req_prio,
  input  logic                mem_rsp_valid,
  input  logic [ROW_BITS-1:0] mem_rsp_data
);
  logic [ROW_AW-1:0] head, row_addr_q, nxt_addr;
  logic [CNT_W-1:0]  q_count;
  logic              q_empty, push_ok, drop, busy, nxt_valid;
  logic              irq_q, ovf_q, ign_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [ROW_BITS-1:0] row;
  logic [31:0]       words [ROW_WORDS];
  logic              cmd_wr, cmd_ok, do_copy, do_free, do_rrow;
  logic              wr_row, wr_ptr, wr_stat, wr_int;
  cmd_e              code;
  logic              unused_wdata;

  assign arr_ready    = 1'b1;
  assign unused_wdata = ^hst_wdata;

  assign code    = cmd_e'(hst_wdata[2:0]);
  assign cmd_wr  = hst_we && (hst_addr == RA_CMD);
  assign cmd_ok  = cmd_wr && !busy;
  assign do_copy = cmd_ok && cfg_master && (code == CMD_COPY) && !q_empty;
  assign do_free = cmd_ok && cfg_master && (code == CMD_FREE);
  assign do_rrow = cmd_ok && (code == CMD_RROW);
  assign wr_row  = hst_we && (hst_addr == RA_ROW);
  assign wr_ptr  = hst_we && (hst_addr == RA_PTR);
  assign wr_stat = hst_we && (hst_addr == RA_STAT);
  assign wr_int  = hst_we && (hst_addr == RA_INT);

  cpq_addr_fifo #(.DEPTH(Q_DEPTH), .AW(ROW_AW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (arr_valid),
    .push_data (arr_addr),
    .pop       (do_free),
    .head      (head),
    .count     (q_count),
    .empty     (q_empty),
    .push_ok   (push_ok),
    .drop      (drop)
  );

  cpq_mem_port #(.AW(ROW_AW), .RW(ROW_BITS)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (do_rrow),
    .start_addr (row_addr_q),
    .start_prio (cfg_prio_en),
    .busy       (busy),
    .req_valid  (mem_req_valid),
    .req_ready  (mem_req_ready),
    .req_addr   (mem_req_addr),
    .req_prio   (mem_req_prio),
    .rsp_valid  (mem_rsp_valid),
    .rsp_data   (mem_rsp_data),
    .row        (row)
  );

  cpq_row_map #(.AW(ROW_AW), .STRIDE(INT_STRIDE)) u_map (
    .ext_exp   (cfg_ext_exp),
    .int_exp   (cfg_int_exp),
    .base      (row_addr_q),
    .nxt_valid (nxt_valid),
    .nxt_addr  (nxt_addr)
  );

  for (genvar g = 0; g < ROW_WORDS; g++) begin : g_word
    assign words[g] = row[g*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_addr_q <= '0;
      ptr_q      <= '0;
      irq_q      <= 1'b0;
      ovf_q      <= 1'b0;
      ign_q      <= 1'b0;
    end else begin
      if (do_copy)     row_addr_q <= head;
      else if (wr_row) row_addr_q <= hst_wdata[ROW_AW-1:0];
      if (wr_ptr) ptr_q <= hst_wdata[PTR_W-1:0];
      if (push_ok)                     irq_q <= 1'b1;
      else if (wr_int && hst_wdata[0]) irq_q <= 1'b0;
      if (drop)                             ovf_q <= 1'b1;
      else if (wr_stat && hst_wdata[ST_OVF]) ovf_q <= 1'b0;
      if (cmd_wr && busy)                   ign_q <= 1'b1;
      else if (wr_stat && hst_wdata[ST_IGN]) ign_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  always_comb begin
    hst_rdata = '0;
    case (hst_addr)
      RA_ROW:  hst_rdata[ROW_AW-1:0] = row_addr_q;
      RA_PTR:  hst_rdata[PTR_W-1:0]  = ptr_q;
      RA_DATA: hst_rdata = words[ptr_q];
      RA_STAT: begin
        hst_rdata[CNT_W-1:0] = q_count;
        hst_rdata[ST_BUSY]   = busy;
        hst_rdata[ST_OVF]    = ovf_q;
        hst_rdata[ST_IGN]    = ign_q;
      end
      RA_INT:  hst_rdata[0] = irq_q;
      RA_NEXT: begin
        hst_rdata[31]         = nxt_valid;
        hst_rdata[ROW_AW-1:0] = nxt_addr;
      end
      default: hst_rdata = '0;
    endcase
  end

  AST_IRQ_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> irq); // R2
  AST_SLAVE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cfg_master && code == CMD_COPY) |=> $stable(row_addr_q)); // R8
  AST_IGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> ign_q); // R9
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q); // R10
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy); // R6
endmodule

// File: tb/cpq_host_seq_tb.sv
module cpq_host_seq_tb_top;
  localparam int AW = 12, DEP = 8, NW = 4, RB = NW * 32;

  logic clk = 0, rst_n = 0;
  logic cfg_master = 1, cfg_ext_exp = 0, cfg_int_exp = 0, cfg_prio_en = 0;
  logic arr_valid = 0, arr_ready;
  logic [AW-1:0] arr_addr = '0;
  logic hst_we = 0;
  logic [2:0] hst_addr = 3'd4;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic irq, mem_req_valid, mem_req_ready = 0, mem_req_prio;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 0;
  logic [RB-1:0] mem_rsp_data = '0;

  cpq_host_seq dut_i (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0, gnt_delay = 2, gnt_wait = 2;
  bit done = 0;

  function automatic logic [31:0] wval(input int base, input int i);
    return {8'hA5, 4'h0, base[11:0], i[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // shared memory model
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_req_ready <= 1'b0;
      gnt_wait      <= gnt_delay;
      mem_rsp_valid <= 1'b1;
      for (int i = 0; i < NW; i++) mem_rsp_data[i*32 +: 32] <= wval(int'(mem_req_addr), i);
    end else if (mem_req_valid) begin
      if (gnt_wait == 0) mem_req_ready <= 1'b1;
      else gnt_wait <= gnt_wait - 1;
    end
  end

  // behavioural reference model
  int q[$];
  int m_row = 0, m_ptr = 0, m_base = 0, m_fetched = -1;
  bit m_irq = 0, m_ovf = 0, m_ign = 0, m_busy = 0, m_prio = 0;

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    s[7:0] = 8'(q.size());
    s[8] = m_busy; s[9] = m_ovf; s[10] = m_ign;
    return s;
  endfunction

  always @(posedge clk) begin
    bit was_busy, pop, cmdw;
    if (!rst_n) begin
      q.delete(); m_row = 0; m_ptr = 0; m_base = 0; m_fetched = -1;
      m_irq = 0; m_ovf = 0; m_ign = 0; m_busy = 0; m_prio = 0;
    end else begin
      was_busy = m_busy; pop = 0;
      cmdw = hst_we && hst_addr == 3'd0;
      if (mem_rsp_valid && m_busy) begin m_busy = 0; m_fetched = m_base; end
      if (hst_we && hst_addr == 3'd4) begin
        if (hst_wdata[9]) m_ovf = 0;
        if (hst_wdata[10]) m_ign = 0;
      end
      if (hst_we && hst_addr == 3'd5 && hst_wdata[0]) m_irq = 0;
      if (hst_we && hst_addr == 3'd1) m_row = int'(hst_wdata[11:0]);
      if (hst_we && hst_addr == 3'd2) m_ptr = int'(hst_wdata[1:0]);
      if (cmdw && was_busy) m_ign = 1;
      else if (cmdw) begin
        if (hst_wdata[2:0] == 3'd1 && cfg_master && q.size() > 0) m_row = q[0];
        if (hst_wdata[2:0] == 3'd2 && cfg_master && q.size() > 0) pop = 1;
        if (hst_wdata[2:0] == 3'd3) begin m_busy = 1; m_base = m_row; m_prio = cfg_prio_en; end
      end
      if (pop) void'(q.pop_front());
      if (arr_valid) begin
        if (q.size() < DEP) begin q.push_back(int'(arr_addr)); m_irq = 1; end
        else m_ovf = 1;
      end
    end
    #2;
    if (rst_n) begin
      chk(irq == m_irq, "R2", "irq per cycle", 32'(irq), 32'(m_irq));
      if (!hst_we && hst_addr == 3'd4)
        chk(hst_rdata == m_status(), "R3", "status per cycle", hst_rdata, m_status());
      if (mem_req_valid) begin
        chk(mem_req_addr == m_base[AW-1:0], "R6", "request address", 32'(mem_req_addr), 32'(m_base));
        chk(mem_req_prio == m_prio, "R12", "request priority", 32'(mem_req_prio), 32'(m_prio));
      end
    end
  end

  task automatic drive(input bit we, input logic [2:0] a, input logic [31:0] d,
                       input bit av, input logic [AW-1:0] aa);
    hst_we = we; hst_addr = a; hst_wdata = d; arr_valid = av; arr_addr = aa;
    @(negedge clk);
    hst_we = 0; hst_addr = 3'd4; arr_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    drive(1, a, d, 0, '0);
  endtask

  task automatic arrive(input logic [AW-1:0] aa);
    drive(0, 3'd4, '0, 1, aa);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req, input string what);
    hst_addr = a;
    #1;
    chk(hst_rdata == exp, req, what, hst_rdata, exp);
    @(negedge clk);
    hst_addr = 3'd4;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && m_busy; i++) @(negedge clk);
  endtask

  task automatic fetch_and_check(input string req);
    wr(3'd0, 32'd3);
    wait_idle();
    for (int i = 0; i < NW; i++) begin
      wr(3'd2, 32'(i));
      rd(3'd3, wval(m_fetched, i), req, "table word");
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd4, 32'h0, "R3", "reset status");
    rd(3'd5, 32'h0, "R2", "reset irq");
    rd(3'd1, 32'h0, "R4", "reset row address");

    // R1 R2 R3: arrivals
    arrive(12'h010); arrive(12'h020); arrive(12'h7F0);
    rd(3'd4, 32'h3, "R3", "count after three arrivals");
    rd(3'd5, 32'h1, "R2", "irq after arrival");
    wr(3'd5, 32'h1);
    rd(3'd5, 32'h0, "R2", "irq cleared");

    // R4 copy head, R11 second row
    wr(3'd0, 32'd1);
    rd(3'd1, 32'h010, "R4", "copied head");
    rd(3'd4, 32'h3, "R4", "copy does not pop");
    rd(3'd6, 32'h8000_0011, "R11", "second row both off");
    cfg_int_exp = 1;
    rd(3'd6, 32'h8000_0110, "R11", "second row internal");
    cfg_ext_exp = 1;
    rd(3'd6, 32'h0, "R11", "no second row external");
    cfg_ext_exp = 0; cfg_int_exp = 0;

    // R6 R7 R12 fetch with priority; R9 command while busy
    cfg_prio_en = 1; gnt_delay = 4; gnt_wait = 4;
    wr(3'd0, 32'd3);
    cfg_prio_en = 0;
    wr(3'd0, 32'd2);
    rd(3'd4, 32'h0000_0503, "R9", "free ignored while busy");
    wait_idle();
    for (int i = 0; i < NW; i++) begin
      wr(3'd2, 32'(i));
      rd(3'd3, wval(16'h010, i), "R7", "table word of row 0x010");
    end
    wr(3'd4, 32'h400);
    rd(3'd4, 32'h3, "R9", "ignore flag cleared");

    // R8 slave gating
    cfg_master = 0;
    wr(3'd0, 32'd2);
    wr(3'd1, 32'h123);
    wr(3'd0, 32'd1);
    rd(3'd1, 32'h123, "R8", "slave copy no effect");
    rd(3'd4, 32'h3, "R8", "slave free no effect");
    gnt_delay = 0; gnt_wait = 0;
    fetch_and_check("R8");
    cfg_master = 1;

    // R5 free then copy
    wr(3'd0, 32'd2);
    rd(3'd4, 32'h2, "R5", "count after free");
    wr(3'd0, 32'd1);
    rd(3'd1, 32'h020, "R5", "next head");
    cfg_int_exp = 1;
    wr(3'd1, 32'h0F8);
    rd(3'd6, 32'h8000_01F8, "R11", "internal stride");
    cfg_int_exp = 0;
    fetch_and_check("R6");

    // R10 fill and overflow
    for (int i = 0; i < 6; i++) arrive(12'(12'h100 + i));
    rd(3'd4, 32'h8, "R3", "queue full");
    arrive(12'hBAD);
    rd(3'd4, 32'h208, "R10", "overflow flag");
    // R1 arrival with free at full
    drive(1, 3'd0, 32'd2, 1, 12'h3C3);
    rd(3'd4, 32'h208, "R1", "swap at full keeps count");
    wr(3'd4, 32'h200);
    rd(3'd4, 32'h8, "R10", "overflow cleared");
    // R2 clear and arrival together
    wr(3'd5, 32'h1);
    wr(3'd0, 32'd2);
    drive(1, 3'd5, 32'h1, 1, 12'h044);
    rd(3'd5, 32'h1, "R2", "set wins over clear");

    // R1 order, R5 empty
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, 32'd1);
      rd(3'd1, 32'(q[0]), "R1", "arrival order");
      wr(3'd0, 32'd2);
    end
    rd(3'd4, 32'h0, "R5", "queue drained");
    wr(3'd1, 32'h055);
    wr(3'd0, 32'd2);
    wr(3'd0, 32'd1);
    rd(3'd4, 32'h0, "R5", "free on empty");
    rd(3'd1, 32'h055, "R4", "copy on empty");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule